// File: doc/BRIEF.md
# Masked Local-Bus Interrupt Controller

This block gathers sixteen level-sensitive interrupt requests from devices on a local peripheral bus. It qualifies them with a software-programmable enable mask and drives a single combined interrupt line toward the processor. It has no latching, acknowledge or nesting. The status seen by the block is the live input level, sampled once per clock, so a request vanishes as soon as its device drops it.

Software reaches the block through a small 16-bit register port with separate read and write strobes. One offset returns a vector code that identifies the most urgent enabled request. The other offset holds the enable mask. Every other offset reads as zero and ignores writes. Read data is registered and appears in the cycle after the read strobe. The combined interrupt output is registered as well, and a mask write takes effect on the same clock edge that stores it.

Top module: `lbus_irq_ctrl`

## Requirements
- R1: Each bit of the internal status follows its `irq_src` input, sampled on every rising clock edge. A source that was high and then goes low no longer counts as pending.
- R2: `irq_out` is registered. After any rising edge it is 1 exactly when the status captured at that edge, ANDed with the mask, is nonzero.
- R3: A read at byte offset 0x000 returns `(k + 1) * 4` in `bus_rdata`, where k is the lowest-numbered source that is both high and enabled. Bit 0 has the highest priority.
- R4: A read at offset 0x000 returns 0 when no enabled source is pending.
- R5: A write at byte offset 0x002 stores all 16 bits of `bus_wdata` as the mask. A later read at 0x002 returns that value.
- R6: A mask write changes `irq_out` on the same clock edge that stores the new mask.
- R7: After reset the mask is 0x0010, the status is 0, `irq_out` is 0 and `bus_rdata` is 0.
- R8: A read at any offset other than 0x000 and 0x002, odd offsets included, returns 0. A write at any such offset leaves the mask and `irq_out` unchanged.
- R9: Reading the vector has no side effect. Repeated reads return the same code, and the mask and `irq_out` stay as they were.
- R10: A source whose mask bit is 0 changes neither `irq_out` nor the vector code, whatever its level.
- R11: `bus_rdata` is registered. It presents the selected value in the cycle after `bus_rd` is sampled high, and presents 0 in the cycle after a clock edge at which `bus_rd` was low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_src | input | 16 | Level-sensitive interrupt requests, bit 0 most urgent |
| bus_addr | input | 12 | Byte offset of the register access |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 16 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 16 | Registered read data, valid the cycle after `bus_rd` |
| irq_out | output | 1 | Combined masked interrupt request, registered |

## Verification
The bench sweeps every single source and every pair of sources with the mask fully open. Against each pattern it checks the vector code and the combined line. An encoder that lets the highest index win, or that omits the +1 or the shift by two, shows up on the pair sweep. Walking single mask bits against dense and sparse request patterns catches masked sources leaking into the vector or the output. Separate checks cover the reset mask value, stray and odd offsets, repeated vector reads, and a mask write that must raise or drop `irq_out` on its own edge. A design that re-evaluated the output one cycle late would fail that last check.

// File: rtl/lbus_irq_pkg.sv
package lbus_irq_pkg;

  // Register selected by a bus offset
  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_VEC  = 2'd1,
    SEL_MASK = 2'd2
  } reg_sel_e;

  // Vector code for source index k: (k + 1) shifted left by two
  localparam int unsigned VEC_SHIFT = 2;

endpackage

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
  parameter int unsigned NUM_SRC = 16,
  parameter int unsigned DATA_W  = 16
) (
  input  logic [NUM_SRC-1:0] req,
  output logic [DATA_W-1:0]  code,
  output logic               any
);
  import lbus_irq_pkg::*;

  // lower_hit[i] is set when some request below index i is active
  logic [NUM_SRC:0]   lower_hit;
  logic [NUM_SRC-1:0] first;

  assign lower_hit[0] = 1'b0;

  genvar gi;
  generate
    for (gi = 0; gi < NUM_SRC; gi++) begin : g_chain
      assign first[gi]         = req[gi] & ~lower_hit[gi];
      assign lower_hit[gi + 1] = lower_hit[gi] | req[gi];
    end
  endgenerate

  assign any = lower_hit[NUM_SRC];

  always_comb begin
    code = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (first[i]) code = code | DATA_W'((i + 1) << VEC_SHIFT);
    end
  end

endmodule

// File: rtl/irq_level_stage.sv
module irq_level_stage #(
  parameter int unsigned NUM_SRC = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] src_lvl,
  input  logic [NUM_SRC-1:0] mask_nxt,
  output logic [NUM_SRC-1:0] status_q,
  output logic               irq_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      status_q <= '0;
      irq_q    <= 1'b0;
    end else begin
      status_q <= src_lvl;
      irq_q    <= |(src_lvl & mask_nxt);
    end
  end

  // R1: the status is the level of the sources at the previous edge
  p_status_follows_r1: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> status_q == $past(src_lvl));

endmodule

// File: rtl/irq_mask_regs.sv
module irq_mask_regs #(
  parameter int unsigned NUM_SRC  = 16,
  parameter int unsigned DATA_W   = 16,
  parameter int unsigned ADDR_W   = 12,
  parameter logic [15:0] MASK_RST = 16'h0010,
  parameter int unsigned VEC_OFS  = 0,
  parameter int unsigned MASK_OFS = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [ADDR_W-1:0]  addr,
  input  logic               wr_en,
  input  logic [DATA_W-1:0]  wr_data,
  input  logic               rd_en,
  input  logic [DATA_W-1:0]  vec_code,
  input  logic               pend_any,
  output logic [NUM_SRC-1:0] mask_q,
  output logic [NUM_SRC-1:0] mask_nxt,
  output logic [DATA_W-1:0]  rd_data
);
  import lbus_irq_pkg::*;

  localparam logic [ADDR_W-1:0]  VEC_A  = ADDR_W'(VEC_OFS);
  localparam logic [ADDR_W-1:0]  MASK_A = ADDR_W'(MASK_OFS);
  localparam logic [NUM_SRC-1:0] MRST   = NUM_SRC'(MASK_RST);

  reg_sel_e sel;

  always_comb begin
    if (addr == VEC_A)       sel = SEL_VEC;
    else if (addr == MASK_A) sel = SEL_MASK;
    else                     sel = SEL_NONE;
  end

  always_comb begin
    mask_nxt = mask_q;
    if (wr_en && sel == SEL_MASK) mask_nxt = wr_data[NUM_SRC-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q  <= MRST;
      rd_data <= '0;
    end else begin
      mask_q <= mask_nxt;
      if (rd_en) begin
        case (sel)
          SEL_VEC:  rd_data <= vec_code;
          SEL_MASK: rd_data <= DATA_W'(mask_q);
          default:  rd_data <= '0;
        endcase
      end else begin
        rd_data <= '0;
      end
    end
  end

  // R5: a mask write is stored as written
  p_mask_written_r5: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == MASK_A) |=> mask_q == $past(wr_data[NUM_SRC-1:0]));

  // R8: writes elsewhere leave the mask alone
  p_stray_write_r8: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr != MASK_A) |=> $stable(mask_q));

  // R8: reads elsewhere return zero
  p_stray_read_r8: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr != MASK_A && addr != VEC_A) |=> rd_data == '0);

  // R4: no enabled pending source gives a zero vector
  p_vec_zero_r4: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr == VEC_A && !pend_any) |=> rd_data == '0);

  // R11: no read strobe gives zero read data
  p_idle_read_r11: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> rd_data == '0);

endmodule

// File: rtl/lbus_irq_ctrl.sv
module lbus_irq_ctrl #(
  parameter int unsigned NUM_SRC  = 16,
  parameter int unsigned DATA_W   = 16,
  parameter int unsigned ADDR_W   = 12,
  parameter logic [15:0] MASK_RST = 16'h0010,
  parameter int unsigned VEC_OFS  = 0,
  parameter int unsigned MASK_OFS = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] irq_src,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic               bus_wr,
  input  logic [DATA_W-1:0]  bus_wdata,
  input  logic               bus_rd,
  output logic [DATA_W-1:0]  bus_rdata,
  output logic               irq_out
);

  logic [NUM_SRC-1:0] status_q;
  logic [NUM_SRC-1:0] mask_q;
  logic [NUM_SRC-1:0] mask_nxt;
  logic [NUM_SRC-1:0] pending;
  logic [DATA_W-1:0]  vec_code;
  logic               pend_any;

  irq_level_stage #(.NUM_SRC(NUM_SRC)) u_level (
    .clk      (clk),
    .rst      (rst),
    .src_lvl  (irq_src),
    .mask_nxt (mask_nxt),
    .status_q (status_q),
    .irq_q    (irq_out)
  );

  assign pending = status_q & mask_q;

  irq_prio_enc #(.NUM_SRC(NUM_SRC), .DATA_W(DATA_W)) u_enc (
    .req  (pending),
    .code (vec_code),
    .any  (pend_any)
  );

  irq_mask_regs #(
    .NUM_SRC  (NUM_SRC),
    .DATA_W   (DATA_W),
    .ADDR_W   (ADDR_W),
    .MASK_RST (MASK_RST),
    .VEC_OFS  (VEC_OFS),
    .MASK_OFS (MASK_OFS)
  ) u_regs (
    .clk      (clk),
    .rst      (rst),
    .addr     (bus_addr),
    .wr_en    (bus_wr),
    .wr_data  (bus_wdata),
    .rd_en    (bus_rd),
    .vec_code (vec_code),
    .pend_any (pend_any),
    .mask_q   (mask_q),
    .mask_nxt (mask_nxt),
    .rd_data  (bus_rdata)
  );

  // R2: the combined line agrees with the registered status and mask
  p_irq_matches_r2: assert property (@(posedge clk) disable iff (rst)
    irq_out == pend_any);

  // R10: masked sources alone never raise the line
  p_masked_quiet_r10: assert property (@(posedge clk) disable iff (rst)
    ((status_q & mask_q) == '0) |-> !irq_out);

endmodule

// File: tb/lbus_irq_ctrl_bench.sv
module lbus_irq_ctrl_bench;

  logic        clk = 1'b0;
  logic        rst;
  logic [15:0] irq_src;
  logic [11:0] bus_addr;
  logic        bus_wr;
  logic [15:0] bus_wdata;
  logic        bus_rd;
  logic [15:0] bus_rdata;
  logic        irq_out;

  int n_checks = 0;
  int n_fails  = 0;
  logic [15:0] cur_mask;

  always #5 clk = ~clk;

  lbus_irq_ctrl u_lbus_irq_ctrl (
    .clk       (clk),
    .rst       (rst),
    .irq_src   (irq_src),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .bus_rd    (bus_rd),
    .bus_rdata (bus_rdata),
    .irq_out   (irq_out)
  );

  function automatic logic [15:0] exp_vec(logic [15:0] s, logic [15:0] m);
    logic [15:0] p;
    p = s & m;
    for (int i = 0; i < 16; i++) begin
      if (p[i]) return 16'((i + 1) * 4);
    end
    return 16'd0;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic set_src(logic [15:0] v);
    @(negedge clk);
    irq_src = v;
    @(posedge clk);
    #1;
  endtask

  task automatic do_write(logic [11:0] a, logic [15:0] d);
    @(negedge clk);
    bus_addr  = a;
    bus_wdata = d;
    bus_wr    = 1'b1;
    @(posedge clk);
    #1;
    bus_wr = 1'b0;
  endtask

  task automatic do_read(logic [11:0] a, output logic [15:0] d);
    @(negedge clk);
    bus_addr = a;
    bus_rd   = 1'b1;
    @(posedge clk);
    #1;
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic final_report();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  endtask

  initial begin
    #1000000;
    n_checks++;
    n_fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    final_report();
  end

  initial begin
    logic [15:0] rd;
    logic [15:0] pats [5];
    rst = 1'b1; irq_src = '0; bus_addr = '0; bus_wr = 1'b0;
    bus_wdata = '0; bus_rd = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    check("R7 irq after reset", irq_out, 0);
    check("R7 rdata after reset", bus_rdata, 0);
    @(negedge clk);
    rst = 1'b0;

    // R7: reset mask
    do_read(12'h002, rd);
    check("R7 mask reset value", rd, 16'h0010);
    do_read(12'h000, rd);
    check("R7 vector empty after reset", rd, 0);

    // R11: idle cycle gives zero read data
    @(posedge clk); #1;
    check("R11 idle rdata", bus_rdata, 0);

    // R1/R2/R3 single-source sweep, mask fully open
    do_write(12'h002, 16'hFFFF);
    cur_mask = 16'hFFFF;
    check("R6 irq after open mask, no source", irq_out, 0);
    for (int i = 0; i < 16; i++) begin
      set_src(16'(1 << i));
      check("R2 single source irq", irq_out, 1);
      do_read(12'h000, rd);
      check("R3 single source vector", rd, 16'((i + 1) * 4));
    end

    // R1: dropping a level clears it
    set_src(16'h0000);
    check("R1 released source irq", irq_out, 0);
    do_read(12'h000, rd);
    check("R4 vector with nothing pending", rd, 0);

    // R3 pair sweep: lower index wins
    for (int i = 0; i < 16; i++) begin
      for (int j = i + 1; j < 16; j++) begin
        set_src(16'((1 << i) | (1 << j)));
        do_read(12'h000, rd);
        check("R3 pair priority", rd, 16'((i + 1) * 4));
      end
    end

    // R10: walking mask bit against several patterns
    pats[0] = 16'hFFFF; pats[1] = 16'hAAAA; pats[2] = 16'h5555;
    pats[3] = 16'h8001; pats[4] = 16'h0000;
    for (int m = 0; m < 16; m++) begin
      do_write(12'h002, 16'(1 << m));
      cur_mask = 16'(1 << m);
      for (int p = 0; p < 6; p++) begin
        logic [15:0] s;
        s = (p == 5) ? ~cur_mask : pats[p];
        set_src(s);
        check("R10 masked irq", irq_out, 32'(((s & cur_mask) != 0)));
        do_read(12'h000, rd);
        check("R10 masked vector", rd, exp_vec(s, cur_mask));
      end
    end

    // R5: mask read back
    do_write(12'h002, 16'hA5C3);
    do_read(12'h002, rd);
    check("R5 mask readback", rd, 16'hA5C3);

    // R6: mask write toggles irq on its own edge
    set_src(16'h0100);
    do_write(12'h002, 16'h0000);
    check("R6 irq drops at mask write edge", irq_out, 0);
    do_write(12'h002, 16'h0100);
    check("R6 irq rises at mask write edge", irq_out, 1);

    // R9: vector reads have no side effect
    set_src(16'h0140);
    do_write(12'h002, 16'h0FF0);
    do_read(12'h000, rd);
    check("R9 first vector read", rd, 16'd28);
    do_read(12'h000, rd);
    check("R9 second vector read", rd, 16'd28);
    check("R9 irq unchanged by read", irq_out, 1);
    do_read(12'h002, rd);
    check("R9 mask unchanged by read", rd, 16'h0FF0);

    // R8: stray offsets
    do_write(12'h004, 16'h0000);
    do_write(12'h003, 16'h0000);
    do_write(12'h802, 16'h0000);
    check("R8 irq after stray writes", irq_out, 1);
    do_read(12'h002, rd);
    check("R8 mask after stray writes", rd, 16'h0FF0);
    do_read(12'h004, rd);
    check("R8 read other offset", rd, 0);
    do_read(12'h001, rd);
    check("R8 read odd offset", rd, 0);
    do_read(12'hFFE, rd);
    check("R8 read high offset", rd, 0);

    // R7: reset mid-run restores defaults
    @(negedge clk); rst = 1'b1;
    @(posedge clk); #1;
    check("R7 irq after mid reset", irq_out, 0);
    @(negedge clk); rst = 1'b0; irq_src = 16'h0010;
    @(posedge clk); #1;
    check("R7 default mask enables source 4", irq_out, 1);
    do_read(12'h000, rd);
    check("R7 vector with default mask", rd, 16'd20);

    final_report();
  end

endmodule